// File: doc/BRIEF.md
# Program Counter Trace Ring Buffer

This block keeps a short history of the program counter values that leave a processor's retirement stage. While capture is on, a 64-bit PC is written into a circular store of `DEPTH` slots. A write index always names the next free slot, so the newest entry sits one slot behind that index, wrapping from slot 0 to the last slot. A capture mode sets which retirements are kept. One mode keeps every retired PC. A second keeps only the targets of control transfers. A third treats the store as a call stack: calls push and returns pop.

A host uses a small word-wide register port. It can switch capture on or off, choose the mode, read and clear the overflow and empty flags, and move the write and read indices. To fetch an entry, the host writes the read index and then reads the upper and lower 32-bit halves of the selected slot. Real PCs are always even. Reset fills every slot with an odd marker, so a host that walks back from the newest entry can stop at the first slot that was never written.

Top module: `pctrace_ring`

## Requirements
- R1: After reset, CTRL (address 0) reads 0x20: capture off, mode 0, FULL clear, EMPTY set. WIDX (address 1) reads 0, the read index is 0, and every slot reads back the odd marker, which defaults to all ones.
- R2: In mode 0 (CTRL bits 2:1 = 0) with capture on (CTRL bit 0), each cycle with `ret_valid` high stores `ret_pc` in the slot named by the write index and advances the index by one modulo DEPTH.
- R3: In mode 1, only retirements with `ret_kind` not equal to 0 are stored. Kind 0 is sequential, 1 is a taken branch or jump, 2 is a call and 3 is a return.
- R4: In mode 2, a call (kind 2) stores and advances. A return (kind 3) moves the write index back by one modulo DEPTH and writes no slot. Kinds 0 and 1 are ignored. Mode 3 stores nothing.
- R5: While capture is off, no slot and no index changes, whatever the retirement inputs do.
- R6: FULL (CTRL bit 4) sets when a store moves the write index from DEPTH-1 to 0. It stays set until the host clears it.
- R7: EMPTY (CTRL bit 5) clears on the first store. A CTRL write clears FULL or EMPTY when that bit of the written value is 0. A 1 in either bit position never sets a flag.
- R8: A write to address 1 loads the write index, and a write to address 2 loads the read index. Each takes the low log2(DEPTH) bits of the data, so writing zero resets the index.
- R9: Address 2 reads the read index in its low bits and DEPTH in bits 23:16. Address 3 returns bits 63:32 of the selected slot, address 4 returns bits 31:0, and every other address reads 0.
- R10: In any cycle with a register write, no retirement is captured.
- R11: Writing zero to CTRL turns capture off and clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ret_valid | input | 1 | A retirement is present this cycle |
| ret_kind | input | 2 | Retirement class: 0 sequential, 1 branch/jump, 2 call, 3 return |
| ret_pc | input | 64 | Retired program counter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |

## Verification
The bench goes after index wrap. A design with a wrong modulus or wrap edge would either never raise FULL or raise it a slot early, and it would leave the newest entry in the wrong slot. Stack returns at index 0 must wrap to the last slot. If they do not, the index would stick or overwrite a slot it should have kept. Flag bits written as 1 must not set FULL or EMPTY. A design that copied the written bits would show both flags together. Register writes during a retirement must block the capture; a design that let it through would move the write index under the host's feet. Random mode changes and even PCs are checked against a slot-by-slot model through the read-index path.

// File: rtl/pctrace_pkg.sv
package pctrace_pkg;

   typedef enum logic [1:0] {
      RK_SEQ    = 2'd0,
      RK_BRANCH = 2'd1,
      RK_CALL   = 2'd2,
      RK_RET    = 2'd3
   } ret_kind_e;

   typedef enum logic [1:0] {
      CM_ALL   = 2'd0,
      CM_FLOW  = 2'd1,
      CM_STACK = 2'd2,
      CM_OFF   = 2'd3
   } cap_mode_e;

   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_WIDX = 3'd1;
   localparam logic [2:0] A_RIDX = 3'd2;
   localparam logic [2:0] A_PCHI = 3'd3;
   localparam logic [2:0] A_PCLO = 3'd4;

   localparam int CTRL_EN_BIT    = 0;
   localparam int CTRL_MODE_LSB  = 1;
   localparam int CTRL_FULL_BIT  = 4;
   localparam int CTRL_EMPTY_BIT = 5;
   localparam int MAXIDX_LSB     = 16;
   localparam int MAXIDX_W       = 8;

endpackage

// File: rtl/pctrace_filter.sv
module pctrace_filter
   import pctrace_pkg::*;
#(
   parameter bit STACK_EN = 1'b1
) (
   input  logic      en,
   input  cap_mode_e mode,
   input  logic      valid,
   input  ret_kind_e kind,
   input  logic      hold,
   output logic      push,
   output logic      pop
);

   logic live;
   logic stk_push;
   logic stk_pop;

   assign live = en && valid && !hold;

   generate
      if (STACK_EN) begin : g_stack
         assign stk_push = (kind == RK_CALL);
         assign stk_pop  = (kind == RK_RET);
      end else begin : g_nostack
         assign stk_push = 1'b0;
         assign stk_pop  = 1'b0;
      end
   endgenerate

   always_comb begin
      push = 1'b0;
      pop  = 1'b0;
      if (live) begin
         unique case (mode)
            CM_ALL:   push = 1'b1;
            CM_FLOW:  push = (kind != RK_SEQ);
            CM_STACK: begin
               push = stk_push;
               pop  = stk_pop;
            end
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/pctrace_store.sv
module pctrace_store #(
   parameter int              DEPTH     = 16,
   parameter int              PC_W      = 64,
   parameter logic [PC_W-1:0] INIT_MARK = '1,
   localparam int             IDX_W     = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [PC_W-1:0]  wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [PC_W-1:0]  rd_data
);

   logic [PC_W-1:0] slot_q [DEPTH];

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q[s] <= INIT_MARK;
            end else if (wr_en && (wr_idx == IDX_W'(s))) begin
               slot_q[s] <= wr_data;
            end
         end
      end
   endgenerate

   assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/pctrace_ring.sv
module pctrace_ring
   import pctrace_pkg::*;
#(
   parameter int              DEPTH     = 16,
   parameter int              PC_W      = 64,
   parameter int              DATA_W    = 32,
   parameter bit              STACK_EN  = 1'b1,
   parameter logic [PC_W-1:0] INIT_MARK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ret_valid,
   input  logic [1:0]        ret_kind,
   input  logic [PC_W-1:0]   ret_pc,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);

   localparam int                  IDX_W     = $clog2(DEPTH);
   localparam logic [IDX_W-1:0]    LAST_IDX  = IDX_W'(DEPTH - 1);
   localparam logic [MAXIDX_W-1:0] MAX_FIELD = MAXIDX_W'(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0 || DEPTH > 128) begin : g_bad_depth
         $error("pctrace_ring: DEPTH must be a power of two from 2 to 128");
      end
      if (PC_W != 2 * DATA_W) begin : g_bad_width
         $error("pctrace_ring: PC_W must be twice DATA_W");
      end
      if (DATA_W < MAXIDX_LSB + MAXIDX_W) begin : g_bad_data
         $error("pctrace_ring: DATA_W too narrow for the index register");
      end
      if (INIT_MARK[0] != 1'b1) begin : g_bad_mark
         $error("pctrace_ring: INIT_MARK must be odd");
      end
   endgenerate

   logic             en_q;
   cap_mode_e        mode_q;
   logic             full_q;
   logic             empty_q;
   logic [IDX_W-1:0] widx_q;
   logic [IDX_W-1:0] ridx_q;
   logic             push;
   logic             pop;
   logic [PC_W-1:0]  sel_pc;

   logic wr_ctrl;
   logic wr_widx;
   logic wr_ridx;

   assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
   assign wr_widx = reg_we && (reg_addr == A_WIDX);
   assign wr_ridx = reg_we && (reg_addr == A_RIDX);

   pctrace_filter #(.STACK_EN(STACK_EN)) u_filter (
      .en    (en_q),
      .mode  (mode_q),
      .valid (ret_valid),
      .kind  (ret_kind_e'(ret_kind)),
      .hold  (reg_we),
      .push  (push),
      .pop   (pop)
   );

   pctrace_store #(
      .DEPTH     (DEPTH),
      .PC_W      (PC_W),
      .INIT_MARK (INIT_MARK)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push),
      .wr_idx  (widx_q),
      .wr_data (ret_pc),
      .rd_idx  (ridx_q),
      .rd_data (sel_pc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         mode_q  <= CM_ALL;
         full_q  <= 1'b0;
         empty_q <= 1'b1;
      end else if (wr_ctrl) begin
         en_q    <= reg_wdata[CTRL_EN_BIT];
         mode_q  <= cap_mode_e'(reg_wdata[CTRL_MODE_LSB +: 2]);
         full_q  <= full_q  & reg_wdata[CTRL_FULL_BIT];
         empty_q <= empty_q & reg_wdata[CTRL_EMPTY_BIT];
      end else if (push) begin
         empty_q <= 1'b0;
         if (widx_q == LAST_IDX) begin
            full_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         widx_q <= '0;
      end else if (wr_widx) begin
         widx_q <= reg_wdata[IDX_W-1:0];
      end else if (push) begin
         widx_q <= widx_q + 1'b1;
      end else if (pop) begin
         widx_q <= widx_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ridx_q <= '0;
      end else if (wr_ridx) begin
         ridx_q <= reg_wdata[IDX_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         A_CTRL: begin
            reg_rdata[CTRL_EN_BIT]         = en_q;
            reg_rdata[CTRL_MODE_LSB +: 2]  = mode_q;
            reg_rdata[CTRL_FULL_BIT]       = full_q;
            reg_rdata[CTRL_EMPTY_BIT]      = empty_q;
         end
         A_WIDX: reg_rdata[IDX_W-1:0] = widx_q;
         A_RIDX: begin
            reg_rdata[IDX_W-1:0]                = ridx_q;
            reg_rdata[MAXIDX_LSB +: MAXIDX_W]   = MAX_FIELD;
         end
         A_PCHI: reg_rdata = sel_pc[PC_W-1:DATA_W];
         A_PCLO: reg_rdata = sel_pc[DATA_W-1:0];
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/pctrace_ring_chk.sv
module pctrace_ring_chk #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ret_valid,
   input logic              reg_we,
   input logic [2:0]        reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              en_q,
   input logic [1:0]        mode_q,
   input logic              full_q,
   input logic              empty_q,
   input logic [IDX_W-1:0]  widx_q
);

   // R7
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_q && empty_q));

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !reg_we) |=> $stable(widx_q));

   // R2
   all_mode_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && mode_q == 2'd0 && ret_valid && !reg_we)
      |=> widx_q == IDX_W'($past(widx_q) + 1'b1));

   // R8
   widx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd1) |=> widx_q == $past(reg_wdata[IDX_W-1:0]));

   // R10
   write_blocks_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr != 3'd0 && reg_addr != 3'd1)
      |=> ($stable(widx_q) && $stable(empty_q)));

   // R6
   full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !(reg_we && reg_addr == 3'd0)) |=> full_q);

endmodule

bind pctrace_ring pctrace_ring_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ret_valid (ret_valid),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .en_q      (en_q),
   .mode_q    (mode_q),
   .full_q    (full_q),
   .empty_q   (empty_q),
   .widx_q    (widx_q)
);

// File: tb/pctrace_ring_tb.sv
module pctrace_ring_tb;

   localparam int          CLK_PERIOD = 10;
   localparam int          DEPTH      = 16;
   localparam logic [63:0] MARK       = 64'hFFFF_FFFF_FFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ret_valid = 1'b0;
   logic [1:0]  ret_kind = 2'd0;
   logic [63:0] ret_pc = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [63:0] m_mem [DEPTH];
   logic [3:0]  m_widx, m_ridx;
   logic [1:0]  m_mode;
   bit          m_en, m_full, m_empty;

   pctrace_ring u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ret_valid (ret_valid),
      .ret_kind  (ret_kind),
      .ret_pc    (ret_pc),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [31:0] exp_ctrl();
      return {26'd0, m_empty, m_full, 1'b0, m_mode, m_en};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(input bit v, input logic [1:0] k, input logic [63:0] pc,
                      input bit we, input logic [2:0] a, input logic [31:0] wd);
      bit push, pop;
      ret_valid = v; ret_kind = k; ret_pc = pc;
      reg_we = we; reg_addr = a; reg_wdata = wd;
      push = 0; pop = 0;
      if (we) begin
         case (a)
            3'd0: begin
               m_en = wd[0]; m_mode = wd[2:1];
               m_full = m_full & wd[4]; m_empty = m_empty & wd[5];
            end
            3'd1: m_widx = wd[3:0];
            3'd2: m_ridx = wd[3:0];
            default: ;
         endcase
      end else if (m_en && v) begin
         case (m_mode)
            2'd0: push = 1;
            2'd1: push = (k != 2'd0);
            2'd2: begin push = (k == 2'd2); pop = (k == 2'd3); end
            default: ;
         endcase
      end
      if (push) begin
         m_mem[m_widx] = pc;
         if (m_widx == 4'd15) m_full = 1;
         m_empty = 0;
         m_widx = m_widx + 4'd1;
      end else if (pop) begin
         m_widx = m_widx - 4'd1;
      end
      @(posedge clk); #1;
      ret_valid = 1'b0; reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] wd);
      cyc(0, 2'd0, 64'd0, 1, a, wd);
   endtask

   task automatic ret(input logic [1:0] k, input logic [63:0] pc);
      cyc(1, k, pc, 0, 3'd0, 32'd0);
   endtask

   task automatic verify(input string tag);
      logic [31:0] d;
      rd(3'd0, d); chk({tag, " ctrl"}, d, exp_ctrl());
      rd(3'd1, d); chk({tag, " widx"}, d, {28'd0, m_widx});
      for (int i = 0; i < DEPTH; i++) begin
         wr(3'd2, i);
         rd(3'd2, d); chk({tag, " R9 ridx"}, d, {8'd0, 8'(DEPTH), 12'd0, m_ridx});
         rd(3'd3, d); chk({tag, " R9 pc_hi"}, d, m_mem[i][63:32]);
         rd(3'd4, d); chk({tag, " R9 pc_lo"}, d, m_mem[i][31:0]);
      end
      rd(3'd5, d); chk({tag, " R9 unmapped"}, d, 32'd0);
   endtask

   function automatic logic [63:0] rpc();
      return {$urandom(), $urandom()} & ~64'd1;
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) m_mem[i] = MARK;
      m_widx = 0; m_ridx = 0; m_mode = 0; m_en = 0; m_full = 0; m_empty = 1;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      rd(3'd0, d); chk("R1 ctrl", d, 32'h20);
      verify("R1");

      // R2 all-retirement mode
      wr(3'd0, 32'h1);
      ret(2'd0, 64'h0000_1000_0000_0010);
      ret(2'd1, 64'h0000_2000_0000_0020);
      ret(2'd3, 64'h0000_3000_0000_0030);
      verify("R2");

      // R7 flag bits written as one never set
      wr(3'd0, 32'h31);
      rd(3'd0, d); chk("R7 no set", d, 32'h01);

      // R6 wrap raises FULL, stays set
      for (int i = 0; i < 13; i++) ret(2'd0, 64'h4000 + 2 * i);
      rd(3'd0, d); chk("R6 full", d, 32'h11);
      ret(2'd0, 64'h5000);
      verify("R6");

      // R11 zero to CTRL, then R5 idle
      wr(3'd0, 32'h0);
      rd(3'd0, d); chk("R11 ctrl", d, 32'h0);
      for (int i = 0; i < 4; i++) ret(2'(i), 64'h6000 + 2 * i);
      verify("R5");

      // R8 index reset
      wr(3'd1, 32'h0);
      wr(3'd2, 32'h0);
      rd(3'd1, d); chk("R8 widx", d, 32'h0);
      rd(3'd2, d); chk("R8 ridx", d, 32'h0010_0000);

      // R3 flow mode
      wr(3'd0, 32'h3);
      for (int i = 0; i < 4; i++) ret(2'(i), 64'h7000 + 16 * i);
      verify("R3");

      // R4 stack mode, including pop wrap at index 0
      wr(3'd1, 32'h0);
      wr(3'd0, 32'h5);
      ret(2'd3, 64'h0);
      rd(3'd1, d); chk("R4 pop wrap", d, 32'd15);
      ret(2'd2, 64'h8000);
      ret(2'd2, 64'h8010);
      ret(2'd2, 64'h8020);
      ret(2'd3, 64'h8030);
      ret(2'd0, 64'h8040);
      ret(2'd1, 64'h8050);
      verify("R4");
      wr(3'd0, 32'h7);
      for (int i = 0; i < 4; i++) ret(2'(i), 64'h9000 + 2 * i);
      verify("R4 mode3");

      // R10 write blocks capture
      wr(3'd0, 32'h1);
      cyc(1, 2'd0, 64'hA000, 1, 3'd2, 32'd3);
      rd(3'd1, d); chk("R10 widx", d, {28'd0, m_widx});
      cyc(1, 2'd2, 64'hA010, 1, 3'd6, 32'd0);
      verify("R10");

      // Random mix
      for (int n = 0; n < 600; n++) begin
         int r;
         r = $urandom_range(0, 63);
         if (r < 3)
            wr(3'd0, {26'd0, 1'($urandom()), 1'($urandom()), 1'b0,
                      2'($urandom()), 1'($urandom_range(0, 3) != 0)});
         else if (r < 4)
            wr(3'd1, $urandom());
         else
            cyc($urandom_range(0, 3) != 0, 2'($urandom()), rpc(), 0, 3'd0, 32'd0);
         if (n % 100 == 99) verify("R2 R3 R4 random");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule